// File: doc/BRIEF.md
# Scan Chain with Parallel-Tap Diagnostic Partner

This block holds a main scan chain together with a second, independent partner chain that has one cell for every main cell. In normal operation each chain shifts on its own enable, from its own scan-in to its own scan-out. Cell 0 is the cell nearest scan-out in both chains, and data moves from the highest-numbered cell toward cell 0.

When diagnostic mode is raised for one clock, every partner cell loads the value held in its own main cell in parallel. The partner chain is then unloaded on its own scan path. Each value stored in the main chain can therefore be read without passing through the main chain's shift links, which may be broken.

A fault hook on the main chain forces the link leaving a chosen main cell to a constant. This emulates a stuck-at defect on that cell's output toward the downstream cell. The testbench applies a load pattern, makes the transfer, and reads the partner chain to work out where the break lies.

Top module: `scan_pair_diag`

## Requirements
- R1: A synchronous active-high reset clears every cell of both chains to 0, so both scan-outs read 0 after reset when the fault hook is off.
- R2: While the main scan enable is high and diagnostic mode is low, main cell N-1 loads the main scan-in and each main cell k below N-1 loads the link leaving cell k+1. Main scan-out presents the link leaving cell 0, so a bit appears there N shifts after it enters.
- R3: While the partner scan enable is high and diagnostic mode is low, partner cell N-1 loads the partner scan-in and each partner cell k loads partner cell k+1. This shifting does not depend on the main chain's enable.
- R4: A clock edge with diagnostic mode high copies every main cell k into partner cell k in that single cycle.
- R5: Diagnostic mode takes priority over both scan enables. During the transfer cycle the main chain holds its contents and the partner chain does not shift.
- R6: A chain whose enable is low, with diagnostic mode low, holds its contents.
- R7: With the fault hook enabled, the link leaving main cell flt_idx is forced to flt_stuck. That link feeds main cell flt_idx-1, or main scan-out when flt_idx is 0. The stored value of the cell and its parallel tap to the partner are unchanged.
- R8: With a stuck-at-0 hook on cell 2, shifting N ones into a cleared main chain and then transferring makes the partner unload 0,0 and then N-2 ones, cell 0 first. This places the break between cells 2 and 1.
- R9: Partner scan-out presents partner cell 0, so an unload returns cells in order 0, 1, ..., N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_si | input | 1 | Main chain scan-in |
| main_se | input | 1 | Main chain shift enable |
| main_so | output | 1 | Main chain scan-out (link leaving cell 0) |
| part_si | input | 1 | Partner chain scan-in |
| part_se | input | 1 | Partner chain shift enable |
| part_so | output | 1 | Partner chain scan-out (partner cell 0) |
| diag_mode | input | 1 | Parallel transfer from main to partner this cycle |
| flt_en | input | 1 | Enables the main-chain fault hook |
| flt_idx | input | IW | Main cell whose outgoing link is forced |
| flt_stuck | input | 1 | Value forced onto that link |

## Verification
On every cycle the assertions check the one-cycle parallel copy, the hold of the main chain during a transfer, partner shifting and holding, main-chain shifting when no fault is present, the clear after reset, and the forced value at scan-out when the hook sits on cell 0. Other behaviour shows only in the bench's scenarios. This covers the end-to-end placement of a bit N shifts after entry, the unload order of the partner, the priority of the transfer with both enables high, and the diagnosis pattern that results from a stuck link in mid-chain.

// File: rtl/scan_diag_pkg.sv
package scan_diag_pkg;

    typedef enum logic [1:0] {
        CH_HOLD  = 2'd0,
        CH_SHIFT = 2'd1,
        CH_LOAD  = 2'd2
    } chain_op_e;

    typedef struct packed {
        logic en;
        logic stuck;
    } fault_kind_t;

    function automatic chain_op_e main_op(input logic diag, input logic se);
        if (diag)    return CH_HOLD;
        else if (se) return CH_SHIFT;
        else         return CH_HOLD;
    endfunction

    function automatic chain_op_e part_op(input logic diag, input logic se);
        if (diag)    return CH_LOAD;
        else if (se) return CH_SHIFT;
        else         return CH_HOLD;
    endfunction

endpackage

// File: rtl/scan_link_fault.sv
module scan_link_fault
    import scan_diag_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  cell_q,
    input  fault_kind_t   fault,
    input  logic [IW-1:0] flt_idx,
    output logic [N-1:0]  link
);
    for (genvar k = 0; k < N; k++) begin : g_link
        assign link[k] = (fault.en && (flt_idx == IW'(k))) ? fault.stuck : cell_q[k];
    end
endmodule

// File: rtl/main_chain.sv
module main_chain
    import scan_diag_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  chain_op_e    op,
    input  logic         si,
    input  logic [N-1:0] link,
    output logic [N-1:0] q
);
    logic [N-1:0] shift_src;

    for (genvar k = 0; k < N; k++) begin : g_src
        if (k == N - 1) begin : g_top
            assign shift_src[k] = si;
        end else begin : g_mid
            assign shift_src[k] = link[k+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (op == CH_SHIFT) begin
            q <= shift_src;
        end
    end
endmodule

// File: rtl/partner_chain.sv
module partner_chain
    import scan_diag_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  chain_op_e    op,
    input  logic         si,
    input  logic [N-1:0] par_in,
    output logic [N-1:0] q
);
    logic [N-1:0] shift_src;

    for (genvar k = 0; k < N; k++) begin : g_src
        if (k == N - 1) begin : g_top
            assign shift_src[k] = si;
        end else begin : g_mid
            assign shift_src[k] = q[k+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (op)
                CH_LOAD:  q <= par_in;
                CH_SHIFT: q <= shift_src;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/scan_pair_diag.sv
module scan_pair_diag
    import scan_diag_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          main_si,
    input  logic          main_se,
    output logic          main_so,
    input  logic          part_si,
    input  logic          part_se,
    output logic          part_so,
    input  logic          diag_mode,
    input  logic          flt_en,
    input  logic [IW-1:0] flt_idx,
    input  logic          flt_stuck
);
    logic [N-1:0] main_q;
    logic [N-1:0] part_q;
    logic [N-1:0] main_link;
    chain_op_e    m_op;
    chain_op_e    p_op;
    fault_kind_t  fault;

    assign fault.en    = flt_en;
    assign fault.stuck = flt_stuck;
    assign m_op        = main_op(diag_mode, main_se);
    assign p_op        = part_op(diag_mode, part_se);

    scan_link_fault #(.N(N), .IW(IW)) u_fault (
        .cell_q  (main_q),
        .fault   (fault),
        .flt_idx (flt_idx),
        .link    (main_link)
    );

    main_chain #(.N(N)) u_main (
        .clk  (clk),
        .rst  (rst),
        .op   (m_op),
        .si   (main_si),
        .link (main_link),
        .q    (main_q)
    );

    partner_chain #(.N(N)) u_part (
        .clk    (clk),
        .rst    (rst),
        .op     (p_op),
        .si     (part_si),
        .par_in (main_q),
        .q      (part_q)
    );

    assign main_so = main_link[0];
    assign part_so = part_q[0];
endmodule

// File: rtl/scan_pair_diag_chk.sv
module scan_pair_diag_chk #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          main_si,
    input logic          main_se,
    input logic          main_so,
    input logic          part_si,
    input logic          part_se,
    input logic          diag_mode,
    input logic          flt_en,
    input logic [IW-1:0] flt_idx,
    input logic          flt_stuck,
    input logic [N-1:0]  main_q,
    input logic [N-1:0]  part_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (main_q == '0 && part_q == '0));

    assert_main_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (main_se && !diag_mode) |=> main_q[N-1] == $past(main_si));

    assert_main_shift_clean_R2: assert property (@(posedge clk) disable iff (rst)
        (main_se && !diag_mode && !flt_en) |=> main_q[N-2:0] == $past(main_q[N-1:1]));

    assert_part_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (part_se && !diag_mode) |=>
            (part_q[N-1] == $past(part_si) && part_q[N-2:0] == $past(part_q[N-1:1])));

    assert_copy_R4: assert property (@(posedge clk) disable iff (rst)
        diag_mode |=> part_q == $past(main_q));

    assert_main_hold_diag_R5: assert property (@(posedge clk) disable iff (rst)
        diag_mode |=> $stable(main_q));

    assert_main_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!main_se && !diag_mode) |=> $stable(main_q));

    assert_part_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!part_se && !diag_mode) |=> $stable(part_q));

    assert_hook_so_R7: assert property (@(posedge clk) disable iff (rst)
        (flt_en && flt_idx == '0) |-> main_so == flt_stuck);
endmodule

bind scan_pair_diag scan_pair_diag_chk #(.N(N), .IW(IW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .main_si   (main_si),
    .main_se   (main_se),
    .main_so   (main_so),
    .part_si   (part_si),
    .part_se   (part_se),
    .diag_mode (diag_mode),
    .flt_en    (flt_en),
    .flt_idx   (flt_idx),
    .flt_stuck (flt_stuck),
    .main_q    (main_q),
    .part_q    (part_q)
);

// File: tb/scan_pair_diag_bench.sv
`timescale 1ns/1ps
module scan_pair_diag_bench;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic main_si = 1'b0, main_se = 1'b0, part_si = 1'b0, part_se = 1'b0;
    logic diag_mode = 1'b0, flt_en = 1'b0, flt_stuck = 1'b0;
    logic [IW-1:0] flt_idx = '0;
    logic main_so, part_so;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    int mref[N];
    int pref[N];

    always #4 clk = ~clk;

    scan_pair_diag #(.N(N)) u_scan_pair_diag (
        .clk(clk), .rst(rst),
        .main_si(main_si), .main_se(main_se), .main_so(main_so),
        .part_si(part_si), .part_se(part_se), .part_so(part_so),
        .diag_mode(diag_mode), .flt_en(flt_en), .flt_idx(flt_idx),
        .flt_stuck(flt_stuck)
    );

    function automatic int link_of(int k);
        if (flt_en && int'(flt_idx) == k) return int'(flt_stuck);
        return mref[k];
    endfunction

    // behavioural reference, updated on the same edge as the design
    always @(posedge clk) begin
        int nm[N];
        int np[N];
        for (int k = 0; k < N; k++) begin
            nm[k] = mref[k];
            np[k] = pref[k];
        end
        if (rst) begin
            for (int k = 0; k < N; k++) begin
                nm[k] = 0;
                np[k] = 0;
            end
        end else if (diag_mode) begin
            for (int k = 0; k < N; k++) np[k] = mref[k];
        end else begin
            if (main_se) begin
                for (int k = 0; k < N - 1; k++) nm[k] = link_of(k + 1);
                nm[N-1] = int'(main_si);
            end
            if (part_se) begin
                for (int k = 0; k < N - 1; k++) np[k] = pref[k+1];
                np[N-1] = int'(part_si);
            end
        end
        for (int k = 0; k < N; k++) begin
            mref[k] = nm[k];
            pref[k] = np[k];
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: compare outputs to the model, then drive the next inputs
    task automatic cyc(input string req, input logic msi, input logic mse,
                       input logic psi, input logic pse, input logic dg);
        @(negedge clk);
        check(req, main_so, logic'(link_of(0)));
        check(req, part_so, logic'(pref[0]));
        main_si = msi; main_se = mse; part_si = psi; part_se = pse; diag_mode = dg;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] pat;
        pat = 8'b1011_0010;
        for (int k = 0; k < N; k++) begin
            mref[k] = 0;
            pref[k] = 0;
        end
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1: cleared after reset
        @(negedge clk);
        check("R1", main_so, 1'b0);
        check("R1", part_so, 1'b0);

        // R2: main shifting, bit appears at scan-out N shifts after entry
        for (int k = 0; k < N; k++) cyc("R2", pat[k], 1'b1, 1'b0, 1'b0, 1'b0);
        cyc("R2", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R2", main_so, pat[0]);
        for (int k = 1; k < N; k++) begin
            cyc("R2", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
            check("R2", main_so, pat[k]);
        end

        // R3 / R6: partner shifts while main holds
        for (int k = 0; k < N; k++) cyc("R3", 1'b1, 1'b0, ~pat[k], 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) cyc("R6", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R6", part_so, ~pat[0]);

        // load main, then R4 transfer and R9 unload order
        for (int k = 0; k < N; k++) cyc("R2", pat[N-1-k], 1'b1, 1'b0, 1'b0, 1'b0);
        cyc("R4", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < N; k++) begin
            cyc("R9", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            check("R9", part_so, pat[N-1-k]);
        end

        // R5: transfer wins over both enables
        cyc("R5", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        cyc("R5", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R5", part_so, pat[N-1]);
        check("R5", main_so, pat[N-1]);

        // R8 / R7: stuck-at-0 on cell 2
        rst = 1'b1;
        cyc("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        flt_en = 1'b1; flt_idx = IW'(2); flt_stuck = 1'b0;
        for (int k = 0; k < N; k++) cyc("R7", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R7", main_so, 1'b0);
        cyc("R8", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < N; k++) begin
            cyc("R8", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            check("R8", part_so, (k >= 2) ? 1'b1 : 1'b0);
        end

        // R7: stuck-at-1 on cell 0 seen at scan-out, cell content intact
        flt_idx = '0; flt_stuck = 1'b1;
        cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R7", main_so, 1'b1);
        cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R7", part_so, 1'b0);
        flt_en = 1'b0;
        for (int k = 0; k < 4; k++) cyc("R6", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R6", main_so, 1'b0);
        finish_run();
    end
endmodule